// File: doc/BRIEF.md
# Checksummed Command Frame Transmitter

This block turns one register-write request into a 32-bit serial command word for a chain of battery-monitor devices. The host presents a 5-bit device address, a 6-bit register address, an 8-bit data value and a flag that addresses every device at once, then pulses `start`. The block packs these fields into the word and computes an 8-bit checksum over the 21 header bits. It adds a fixed three-bit tail and shifts the word out most significant bit first. The link uses clock polarity 0 and phase 1.

The serial clock comes from the system clock through a parameterised divider. Each half period lasts `HALF_DIV` system cycles, so the rate can be held below the link's 700 kHz ceiling. While a frame is on the wire, the block ignores further requests. It reports the end of the frame with a one-cycle `done` pulse.

Top module: `cmd_frame_tx`

## Requirements
- R1: The frame layout is as follows. Bits 31:27 hold the device address, bits 26:21 the register address, bits 20:13 the data value and bit 12 the broadcast flag. Bit 11 is always 0.
- R2: Bits 10:3 hold the remainder of frame bits 31:11, read as a 21-bit polynomial with bit 31 highest, divided by x^8+x^5+x^3+x^2+x+1. The remainder starts from zero and no zero bits are appended to the message.
- R3: Bits 2:0 are always the constant 010 and take no part in the checksum.
- R4: The word goes out bit 31 first. While `cs_n` is low, `mosi` changes only in the cycle where `sclk` rises. The receiver samples on the falling edge.
- R5: `sclk` idles low whenever `cs_n` is high. Each high or low phase of `sclk` lasts `HALF_DIV` system clock cycles.
- R6: Each frame holds `cs_n` low for exactly 32 `sclk` periods: 32 rising and 32 falling edges.
- R7: A `start` pulse while `busy` is high is ignored. It neither changes the frame being sent nor queues a new one.
- R8: `done` is high for exactly one cycle: the cycle after the one in which `cs_n` returns high.
- R9: After reset, `cs_n` is high and `sclk`, `mosi`, `busy` and `done` are low.
- R10: Device 31, register 0, value 0 and broadcast clear give the poll word 0xF800030A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one frame; sampled while idle |
| dev_addr | input | 5 | Target device address |
| reg_addr | input | 6 | Target register address |
| wr_val | input | 8 | Data value to write |
| bcast | input | 1 | Address all devices in the chain |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the frame ends |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |

## Verification
Corrupt packing or checksum state shows up on `mosi` within the frame it affects. The bad bits appear at the falling edges where they are sampled, so a whole frame is enough to catch them. An edge counter off by one shows up at the end of the same frame: the number of `sclk` edges inside `cs_n` is wrong, or `cs_n` returns high late or early. A state machine that takes a second request while busy shows up within a few hundred cycles of `done`, as an unexpected fall of `cs_n`.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
   localparam int FRAME_W = 32;
   localparam int DEV_W   = 5;
   localparam int REG_W   = 6;
   localparam int VAL_W   = 8;
   localparam int CRC_W   = 8;
   localparam int HDR_W   = DEV_W + REG_W + VAL_W + 1 + 1;
   localparam logic [2:0] TAIL_BITS = 3'b010;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_TAIL,
      ST_FIN
   } tx_state_e;

   typedef struct packed {
      logic [DEV_W-1:0] dev;
      logic [REG_W-1:0] regad;
      logic [VAL_W-1:0] val;
      logic             all;
   } cmd_fields_t;
endpackage

// File: rtl/cmd_frame_pack.sv
module cmd_frame_pack
   import cmd_frame_pkg::*;
#(
   parameter logic [CRC_W-1:0] CRC_POLY = 8'h2F
) (
   input  cmd_fields_t        fields,
   output logic [FRAME_W-1:0] frame
);
   localparam int TAIL_W = FRAME_W - HDR_W - CRC_W;

   logic [HDR_W-1:0] header;
   logic [CRC_W-1:0] rem_chain [0:HDR_W];

   assign header       = {fields.dev, fields.regad, fields.val, fields.all, 1'b0};
   assign rem_chain[0] = '0;

   // Horner division: shift one header bit in per stage, reduce by the polynomial.
   genvar gi;
   generate
      for (gi = 0; gi < HDR_W; gi++) begin : g_div
         assign rem_chain[gi+1] = {rem_chain[gi][CRC_W-2:0], header[HDR_W-1-gi]}
                                  ^ (rem_chain[gi][CRC_W-1] ? CRC_POLY : '0);
      end
      if (TAIL_W != 3) begin : g_bad_tail
         $error("cmd_frame_pack: frame layout leaves no 3-bit tail");
      end
   endgenerate

   assign frame = {header, rem_chain[HDR_W], TAIL_BITS};
endmodule

// File: rtl/cmd_frame_clkdiv.sv
module cmd_frame_clkdiv #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign tick = run && (cnt == CW'(HALF_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (!run)  cnt <= '0;
            else if (tick)  cnt <= '0;
            else            cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cmd_frame_shifter.sv
module cmd_frame_shifter
   import cmd_frame_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               tick,
   output logic               run,
   output logic               busy,
   output logic               done,
   output logic               sclk,
   output logic               cs_n,
   output logic               mosi
);
   localparam int EW = $clog2(FRAME_W);

   tx_state_e          state;
   logic [FRAME_W-1:0] shreg;
   logic [EW-1:0]      fall_cnt;

   assign run  = (state == ST_SHIFT) || (state == ST_TAIL);
   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         fall_cnt <= '0;
         done     <= 1'b0;
         sclk     <= 1'b0;
         cs_n     <= 1'b1;
         mosi     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  shreg    <= frame_in;
                  fall_cnt <= '0;
                  cs_n     <= 1'b0;
                  state    <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk  <= 1'b1;
                     mosi  <= shreg[FRAME_W-1];
                     shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  end else begin
                     sclk <= 1'b0;
                     if (fall_cnt == EW'(FRAME_W - 1)) state <= ST_TAIL;
                     else                              fall_cnt <= fall_cnt + 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n  <= 1'b1;
                  mosi  <= 1'b0;
                  state <= ST_FIN;
               end
            end
            ST_FIN: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
   import cmd_frame_pkg::*;
#(
   parameter int               HALF_DIV = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 8'h2F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEV_W-1:0] dev_addr,
   input  logic [REG_W-1:0] reg_addr,
   input  logic [VAL_W-1:0] wr_val,
   input  logic             bcast,
   output logic             busy,
   output logic             done,
   output logic             sclk,
   output logic             cs_n,
   output logic             mosi
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("cmd_frame_tx: HALF_DIV must be at least 1");
      end
   endgenerate

   cmd_fields_t        fields;
   logic [FRAME_W-1:0] frame;
   logic               tick;
   logic               run;

   assign fields = '{dev: dev_addr, regad: reg_addr, val: wr_val, all: bcast};

   cmd_frame_pack #(.CRC_POLY(CRC_POLY)) u_pack (
      .fields (fields),
      .frame  (frame)
   );

   cmd_frame_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   cmd_frame_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .frame_in (frame),
      .tick     (tick),
      .run      (run),
      .busy     (busy),
      .done     (done),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .mosi     (mosi)
   );
endmodule

// File: rtl/cmd_frame_tx_chk.sv
module cmd_frame_tx_chk
   import cmd_frame_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic cs_n,
   input logic mosi
);
   localparam int RW = $clog2(FRAME_W) + 1;

   logic          sclk_q;
   logic [RW-1:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= sclk;
         if (cs_n)                rise_cnt <= '0;
         else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && (mosi != $past(mosi))) |-> (sclk && !$past(sclk))); // R4
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R5
   AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_cnt == RW'(FRAME_W))); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !$fell(cs_n)); // R7
   AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && $past(cs_n) && !$past(cs_n, 2))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
endmodule

bind cmd_frame_tx cmd_frame_tx_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .sclk  (sclk),
   .cs_n  (cs_n),
   .mosi  (mosi)
);

// File: tb/cmd_frame_tx_bench.sv
module cmd_frame_tx_bench;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [4:0] dev_addr = '0;
   logic [5:0] reg_addr = '0;
   logic [7:0] wr_val = '0;
   logic       bcast = 1'b0;
   logic       busy, done, sclk, cs_n, mosi;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cmd_frame_tx #(.HALF_DIV(HALF)) u_cmd_frame_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
      .reg_addr(reg_addr), .wr_val(wr_val), .bcast(bcast), .busy(busy),
      .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Expected word from the requirements: fields, remainder by long division, tail.
   function automatic logic [31:0] model(input logic [4:0] d, input logic [5:0] r,
                                         input logic [7:0] v, input logic b);
      logic [20:0] hdr;
      logic [20:0] work;
      hdr  = {d, r, v, b, 1'b0};
      work = hdr;
      for (int i = 20; i >= 8; i--)
         if (work[i]) work = work ^ (21'h12F << (i - 8));
      return {hdr, work[7:0], 3'b010};
   endfunction

   // Sends one frame, optionally firing a second start mid-frame, and checks it.
   task automatic run_frame(input logic [4:0] d, input logic [5:0] r,
                            input logic [7:0] v, input logic b,
                            input bit poke_busy, input string tag);
      logic [31:0] exp, got;
      int rises, falls, cyc, last_rise, bad_mosi, bad_period;
      bit prev_s, prev_m, prev_cs, seen_up, done_ok;
      exp = model(d, r, v, b);
      got = '0; rises = 0; falls = 0; cyc = 0; last_rise = -1;
      bad_mosi = 0; bad_period = 0; seen_up = 0; done_ok = 0;
      @(negedge clk);
      dev_addr = d; reg_addr = r; wr_val = v; bcast = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev_s = sclk; prev_m = mosi; prev_cs = cs_n;
      check(cs_n == 1'b0 && busy, {tag, " R6 cs low after start"}, {30'd0, busy, cs_n}, 32'd2);
      while (cyc < 2000) begin
         if (poke_busy && cyc == 40) begin
            dev_addr = ~d; reg_addr = ~r; wr_val = ~v; bcast = ~b; start = 1'b1;
         end else if (poke_busy && cyc == 41) begin
            start = 1'b0;
         end
         @(posedge clk); #1;
         cyc++;
         if (!cs_n && sclk && !prev_s) begin
            rises++;
            if (last_rise >= 0 && cyc - last_rise != 2 * HALF) bad_period++;
            last_rise = cyc;
         end
         if (!cs_n && !sclk && prev_s) begin
            falls++;
            got = {got[30:0], mosi};
         end
         if (!cs_n && !prev_cs && mosi != prev_m && !(sclk && !prev_s)) bad_mosi++;
         if (seen_up) begin
            done_ok = done;
            break;
         end
         if (cs_n && !prev_cs) begin
            seen_up = 1;
            check(!done, {tag, " R8 done not with cs rise"}, {31'd0, done}, 32'd0);
            check(!sclk, {tag, " R5 sclk idle low"}, {31'd0, sclk}, 32'd0);
         end
         prev_s = sclk; prev_m = mosi; prev_cs = cs_n;
      end
      check(got == exp, {tag, " R1 R2 R3 R4 frame bits"}, got, exp);
      check(rises == 32 && falls == 32, {tag, " R6 edge count"}, rises, 32);
      check(bad_mosi == 0, {tag, " R4 mosi moved off rising edge"}, bad_mosi, 0);
      check(bad_period == 0, {tag, " R5 sclk period"}, bad_period, 0);
      check(done_ok, {tag, " R8 done one cycle after cs rise"}, {31'd0, done_ok}, 32'd1);
      @(posedge clk); #1;
      check(!done && !busy, {tag, " R8 done single cycle"}, {30'd0, busy, done}, 32'd0);
      if (poke_busy) begin
         bit fell;
         fell = 0;
         for (int k = 0; k < 200; k++) begin
            @(posedge clk); #1;
            if (!cs_n) fell = 1;
         end
         check(!fell, {tag, " R7 no queued frame"}, {31'd0, fell}, 32'd0);
      end
   endtask

   task automatic test_reset();
      check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && !busy && !done,
            "R9 reset state", {27'd0, cs_n, sclk, mosi, busy, done}, 32'h10);
   endtask

   task automatic test_poll();
      check(model(5'h1F, 6'h0, 8'h00, 1'b0) == 32'hF800030A, "R10 poll word model",
            model(5'h1F, 6'h0, 8'h00, 1'b0), 32'hF800030A);
      run_frame(5'h1F, 6'h00, 8'h00, 1'b0, 0, "R10 poll");
   endtask

   task automatic test_patterns();
      run_frame(5'h00, 6'h0D, 8'h30, 1'b1, 0, "R1 broadcast");
      run_frame(5'h03, 6'h14, 8'hA5, 1'b0, 0, "R2 device write");
      run_frame(5'h15, 6'h2A, 8'hFF, 1'b1, 0, "R3 all ones");
      run_frame(5'h00, 6'h00, 8'h00, 1'b0, 0, "R2 zero header");
   endtask

   task automatic test_busy_start();
      run_frame(5'h09, 6'h1C, 8'h5C, 1'b0, 1, "R7 start while busy");
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      test_reset();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      test_reset();
      test_poll();
      test_patterns();
      test_busy_start();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule